// File: doc/BRIEF.md
# Register-Mapped Watchdog Timer

This block is a watchdog that software arms and services through a small byte-wide register port. A down-counter holds a period in whole seconds. A prescaler derived from the system clock marks each second. Software reloads the counter by writing one fixed byte to a dedicated service address. Any other value written there is dropped, so a stray write cannot keep a hung system alive.

The timer has two arming modes, normal and recovery, and a lock bit that freezes its configuration while it runs. On expiry it can raise a system-reset pulse, a timeout-indication pulse, or both, each under its own enable bit. Two sticky flags report which mode fired. After an expiry the counter stays stopped until software services it again. A period of zero makes the watchdog expire as soon as it is armed, which gives software a way to force a reset.

Top module: `wdog_regblk`

## Requirements
- R1: After reset all outputs are low and the control and period registers read as 0x00.
- R2: Address 0 is control, address 1 is period and address 2 is service. Control keeps bits 7, 6, 2, 1 and 0, and its bits 3 to 5 read as zero. Period keeps all eight bits. Reading the service address returns 0x00.
- R3: Writing 0x6B to address 2 reloads the counter from the period register and restarts the prescaler. Any other value written there leaves the counter unchanged.
- R4: With control bit 0 (normal) or bit 1 (recovery) set, a period of T causes expiry, and the enabled outputs rise at the clock edge T*CLK_PER_SEC+1 cycles after the edge that sampled the arming or service write.
- R5: With a period of zero, a service write followed by an arming write makes the outputs rise at the clock edge directly after the arming write.
- R6: While control bit 2 (lock) is set and either enable bit is set, writes to control and period are ignored. The lock then clears only on reset.
- R7: On expiry, sys_rst_o is high for PULSE_LEN cycles if control bit 6 was set, and tmo_ind_o is high for PULSE_LEN cycles if control bit 7 was set. A disabled output stays low.
- R8: On expiry, fired_recovery_o is set if control bit 1 was set, and fired_normal_o is set otherwise. A valid service write clears both flags.
- R9: After an expiry the counter stops and nothing further fires until a valid service write re-arms it.
- R10: Clearing control bits 0 and 1 stops the countdown, and no expiry occurs while both are clear.
- R11: Read data appears one cycle after the edge that samples bus_rd and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| sys_rst_o | output | 1 | System-reset pulse on expiry |
| tmo_ind_o | output | 1 | Timeout-indication pulse on expiry |
| fired_normal_o | output | 1 | Last expiry was in normal mode |
| fired_recovery_o | output | 1 | Last expiry was in recovery mode |

## Verification
Two situations are hard to reach from the ports. The first is a write that lands while the lock is held. The second is a service write with the wrong value issued partway through a countdown. In both cases nothing visible changes right away, and the only evidence is when the expiry pulse arrives. The bench therefore arms the timer and counts every cycle spent on intermediate bus writes and reads. It then checks that the expiry edge arrives exactly as many cycles later as the untouched countdown predicts. The prescaler is made small so that each second lasts a few clocks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PER  = 2'd1;
  localparam logic [1:0] ADDR_SVC  = 2'd2;
  localparam logic [7:0] SVC_MAGIC = 8'h6B;

  typedef struct packed {
    logic ind_en;
    logic rst_en;
    logic lock;
    logic en_rec;
    logic en_norm;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
    ctrl_t c;
    c.en_norm = b[0];
    c.en_rec  = b[1];
    c.lock    = b[2];
    c.rst_en  = b[6];
    c.ind_en  = b[7];
    return c;
  endfunction

  function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
    return {c.ind_en, c.rst_en, 3'b000, c.lock, c.en_rec, c.en_norm};
  endfunction

  function automatic logic ctrl_armed(input ctrl_t c);
    return c.en_norm | c.en_rec;
  endfunction

  function automatic logic is_service(input logic wr, input logic [1:0] a,
                                      input logic [7:0] d);
    return wr && (a == ADDR_SVC) && (d == SVC_MAGIC);
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output ctrl_t      ctrl_q,
  output logic [7:0] per_q,
  output logic [7:0] bus_rdata,
  output logic       svc_ok,
  output logic       locked
);

  assign locked = ctrl_q.lock && ctrl_armed(ctrl_q);
  assign svc_ok = is_service(bus_wr, bus_addr, bus_wdata);

  logic wr_ctrl, wr_per;
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL) && !locked;
  assign wr_per  = bus_wr && (bus_addr == ADDR_PER) && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_from_byte(bus_wdata);
      if (wr_per)  per_q  <= bus_wdata;
    end
  end

  logic [7:0] rd_mux;
  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: rd_mux = ctrl_to_byte(ctrl_q);
      ADDR_PER:  rd_mux = per_q;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int unsigned CLK_PER_SEC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  localparam int unsigned PW = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_SEC - 1);

  logic [PW-1:0] presc_q;

  assign tick = run && (presc_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)              presc_q <= '0;
    else if (restart || !run) presc_q <= '0;
    else if (tick)           presc_q <= '0;
    else                     presc_q <= presc_q + 1'b1;
  end

endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed,
  input  logic       mode_rec,
  input  logic       rst_en,
  input  logic       ind_en,
  input  logic       svc_ok,
  input  logic [7:0] per,
  input  logic       tick,
  output logic       run,
  output logic       expire_ev,
  output logic [7:0] cnt_q,
  output logic       pulse_active,
  output logic       sys_rst_o,
  output logic       tmo_ind_o,
  output logic       fired_n_q,
  output logic       fired_r_q
);

  localparam int unsigned PCW = $clog2(PULSE_LEN + 1);

  logic expired_q;
  logic [PCW-1:0] pulse_q;
  logic rst_lat_q, ind_lat_q;

  assign run       = armed && !expired_q;
  assign expire_ev = run && (cnt_q == 8'd0) && !svc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (svc_ok)                 cnt_q <= per;
    else if (tick && cnt_q != 8'd0)  cnt_q <= cnt_q - 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         expired_q <= 1'b0;
    else if (svc_ok)    expired_q <= 1'b0;
    else if (expire_ev) expired_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q   <= '0;
      rst_lat_q <= 1'b0;
      ind_lat_q <= 1'b0;
    end else if (expire_ev) begin
      pulse_q   <= PCW'(PULSE_LEN);
      rst_lat_q <= rst_en;
      ind_lat_q <= ind_en;
    end else if (pulse_q != '0) begin
      pulse_q   <= pulse_q - 1'b1;
    end
  end

  assign pulse_active = (pulse_q != '0);
  assign sys_rst_o    = pulse_active && rst_lat_q;
  assign tmo_ind_o    = pulse_active && ind_lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n || svc_ok) begin
      fired_n_q <= 1'b0;
      fired_r_q <= 1'b0;
    end else if (expire_ev) begin
      fired_r_q <= mode_rec;
      fired_n_q <= !mode_rec;
    end
  end

endmodule

// File: rtl/wdog_regblk.sv
module wdog_regblk
  import wdog_pkg::*;
#(
  parameter int unsigned CLK_PER_SEC = 50_000_000,
  parameter int unsigned PULSE_LEN   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sys_rst_o,
  output logic       tmo_ind_o,
  output logic       fired_normal_o,
  output logic       fired_recovery_o
);

  ctrl_t      ctrl_q;
  logic [7:0] ctrl_byte;
  logic [7:0] per_q;
  logic [7:0] cnt_q;
  logic       svc_ok, locked, tick, run, expire_ev, pulse_active, armed;

  assign ctrl_byte = ctrl_to_byte(ctrl_q);
  assign armed     = ctrl_armed(ctrl_q);

  wdog_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_q    (ctrl_q),
    .per_q     (per_q),
    .bus_rdata (bus_rdata),
    .svc_ok    (svc_ok),
    .locked    (locked)
  );

  wdog_tick #(.CLK_PER_SEC(CLK_PER_SEC)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (svc_ok),
    .tick    (tick)
  );

  wdog_core #(.PULSE_LEN(PULSE_LEN)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .armed        (armed),
    .mode_rec     (ctrl_q.en_rec),
    .rst_en       (ctrl_q.rst_en),
    .ind_en       (ctrl_q.ind_en),
    .svc_ok       (svc_ok),
    .per          (per_q),
    .tick         (tick),
    .run          (run),
    .expire_ev    (expire_ev),
    .cnt_q        (cnt_q),
    .pulse_active (pulse_active),
    .sys_rst_o    (sys_rst_o),
    .tmo_ind_o    (tmo_ind_o),
    .fired_n_q    (fired_normal_o),
    .fired_r_q    (fired_recovery_o)
  );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] ctrl_byte,
  input logic [7:0] per_q,
  input logic [7:0] cnt_q,
  input logic       locked,
  input logic       armed,
  input logic       tick,
  input logic       expire_ev,
  input logic       pulse_active,
  input logic       sys_rst_o,
  input logic       tmo_ind_o,
  input logic       fired_normal_o,
  input logic       fired_recovery_o
);

  a_r3_kick_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && bus_wdata == 8'h6B) |=> (cnt_q == $past(per_q)));

  a_r3_bad_kick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && bus_wdata != 8'h6B && !tick) |=> $stable(cnt_q));

  a_r6_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(ctrl_byte) && $stable(per_q)));

  a_r7_out_within_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_o || tmo_ind_o) |-> pulse_active);

  a_r7_pulse_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_active) |-> $past(expire_ev));

  a_r8_one_mode_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fired_normal_o, fired_recovery_o}));

  a_r9_single_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire_ev |=> !expire_ev);

  a_r10_idle_no_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !expire_ev);

endmodule

bind wdog_regblk wdog_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .bus_wr           (bus_wr),
  .bus_addr         (bus_addr),
  .bus_wdata        (bus_wdata),
  .ctrl_byte        (ctrl_byte),
  .per_q            (per_q),
  .cnt_q            (cnt_q),
  .locked           (locked),
  .armed            (armed),
  .tick             (tick),
  .expire_ev        (expire_ev),
  .pulse_active     (pulse_active),
  .sys_rst_o        (sys_rst_o),
  .tmo_ind_o        (tmo_ind_o),
  .fired_normal_o   (fired_normal_o),
  .fired_recovery_o (fired_recovery_o)
);

// File: tb/tb_wdog_regblk.sv
module tb_wdog_regblk;

  localparam int P  = 4;
  localparam int PL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic sys_rst_o, tmo_ind_o, fired_normal_o, fired_recovery_o;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wdog_regblk #(.CLK_PER_SEC(P), .PULSE_LEN(PL)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst_o(sys_rst_o), .tmo_ind_o(tmo_ind_o),
    .fired_normal_o(fired_normal_o), .fired_recovery_o(fired_recovery_o)
  );

  function automatic int expiry_delay(input int t);
    return t * P + 1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic measure(input int maxc, output int n);
    n = 0;
    while (!sys_rst_o && !tmo_ind_o && n < maxc) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic quiet(input int cyc, output int seen);
    seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (sys_rst_o || tmo_ind_o) seen = 1;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R1", "sys_rst_o", sys_rst_o, 0);
    chk("R1", "tmo_ind_o", tmo_ind_o, 0);
    chk("R1", "flags", {fired_normal_o, fired_recovery_o}, 0);
    rd(2'd0, d); chk("R1", "ctrl", d, 0);
    rd(2'd1, d); chk("R1", "period", d, 0);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'hF8);
    rd(2'd0, d); chk("R2", "ctrl bits 3-5 zero", d, 8'hC0);
    wr(2'd1, 8'hA5);
    rd(2'd1, d); chk("R2", "period", d, 8'hA5);
    repeat (3) @(negedge clk);
    chk("R11", "rdata held", bus_rdata, 8'hA5);
    rd(2'd2, d); chk("R2", "service reads zero", d, 0);
  endtask

  task automatic t_normal();
    int n, w, seen;
    do_reset();
    wr(2'd1, 8'd3); wr(2'd2, 8'h6B); wr(2'd0, 8'h41);
    measure(200, n);
    chk("R4", "expiry delay", n, expiry_delay(3));
    chk("R7", "sys_rst_o on", sys_rst_o, 1);
    chk("R7", "tmo_ind_o masked", tmo_ind_o, 0);
    chk("R8", "normal flag", {fired_normal_o, fired_recovery_o}, 2'b10);
    w = 0;
    while (sys_rst_o && w < 100) begin @(negedge clk); w++; end
    chk("R7", "pulse width", w, PL);
    wr(2'd2, 8'h00);
    quiet(40, seen);
    chk("R9", "no re-fire after bad kick", seen, 0);
  endtask

  task automatic t_recovery();
    int n, w;
    do_reset();
    wr(2'd1, 8'd1); wr(2'd2, 8'h6B); wr(2'd0, 8'h82);
    measure(200, n);
    chk("R4", "recovery delay", n, expiry_delay(1));
    chk("R7", "tmo_ind_o on", tmo_ind_o, 1);
    chk("R7", "sys_rst_o masked", sys_rst_o, 0);
    chk("R8", "recovery flag", {fired_normal_o, fired_recovery_o}, 2'b01);
    w = 0;
    while (tmo_ind_o && w < 100) begin @(negedge clk); w++; end
    wr(2'd2, 8'h6B);
    chk("R8", "flags cleared by kick", {fired_normal_o, fired_recovery_o}, 0);
    measure(200, n);
    chk("R9", "re-armed by kick", n, expiry_delay(1));
  endtask

  task automatic t_expire_now();
    int n;
    do_reset();
    wr(2'd1, 8'd0); wr(2'd2, 8'h6B); wr(2'd0, 8'h41);
    measure(50, n);
    chk("R5", "zero period delay", n, 1);
  endtask

  task automatic t_kick();
    int n;
    do_reset();
    wr(2'd1, 8'd2); wr(2'd2, 8'h6B); wr(2'd0, 8'h41);
    repeat (5) @(negedge clk);
    wr(2'd2, 8'h6A);
    measure(200, n);
    chk("R3", "wrong value ignored", n, expiry_delay(2) - 6);
    do_reset();
    wr(2'd1, 8'd2); wr(2'd2, 8'h6B); wr(2'd0, 8'h41);
    repeat (5) @(negedge clk);
    wr(2'd2, 8'h6B);
    measure(200, n);
    chk("R3", "valid kick reloads", n, expiry_delay(2));
  endtask

  task automatic t_lock();
    logic [7:0] d;
    int n;
    do_reset();
    wr(2'd1, 8'd2); wr(2'd2, 8'h6B); wr(2'd0, 8'h45);
    wr(2'd1, 8'd9); wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R6", "ctrl write ignored", d, 8'h45);
    rd(2'd1, d); chk("R6", "period write ignored", d, 2);
    measure(200, n);
    chk("R6", "countdown untouched", n, expiry_delay(2) - 4);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R6", "lock held after expiry", d, 8'h45);
    do_reset();
    rd(2'd0, d); chk("R6", "reset clears lock", d, 0);
  endtask

  task automatic t_stop();
    int seen;
    do_reset();
    wr(2'd1, 8'd1); wr(2'd2, 8'h6B); wr(2'd0, 8'h41);
    repeat (2) @(negedge clk);
    wr(2'd0, 8'h40);
    quiet(30, seen);
    chk("R10", "disabled timer silent", seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_readback();
    t_normal();
    t_recovery();
    t_expire_now();
    t_kick();
    t_lock();
    t_stop();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule